// File: doc/BRIEF.md
# Fetch-Stage Branch Direction and Target Predictor

This block sits beside the instruction fetch stage. Each cycle the fetch PC is presented on the lookup port, and the block answers in the same cycle with the address to fetch next. A table of 2-bit saturating counters gives the taken/not-taken direction. A small direct-mapped, tagged cache of branch target addresses gives the destination. The fetch stage is redirected to the cached target only when the cache holds a matching entry and the counter leans taken. In every other case the answer is the sequential address, PC plus 4.

The execute stage trains the block through a registered update port. It supplies the resolved branch PC, whether the branch was taken, and where it went. The update steps the counter for that PC one position toward the outcome. A taken outcome also writes the target cache entry. Because updates commit at the clock edge, a lookup in the same cycle as an update always reads the older contents.

Top module: `bp_fetch_predictor`

## Requirements
- R1: After reset, every counter is in the weakly not-taken state and every target entry is invalid. Any lookup then yields not-taken with next PC equal to the lookup PC plus 4.
- R2: Whenever the prediction is not-taken, the next PC equals the lookup PC plus 4, computed modulo 2^32.
- R3: A target entry hits only when its valid bit is set and its stored tag equals the lookup PC bits above the entry index. The entry index is taken from the PC starting at bit 2. On a tag mismatch the prediction is not-taken even when the counter leans taken.
- R4: The prediction is taken when the counter's upper bit is 1 and the target entry hits. In that case the next PC is the cached target in the same cycle as the lookup.
- R5: Counter encoding is 00 strongly not-taken, 01 weakly not-taken, 10 weakly taken and 11 strongly taken, and the counter saturates at 00 and 11. From a strong state, one opposite outcome leaves the prediction unchanged; two consecutive opposite outcomes reverse it.
- R6: A taken update writes valid, tag and target into the entry its PC indexes, replacing any earlier branch there. A not-taken update leaves the target entry untouched.
- R7: When an update and a lookup address the same entry in one cycle, the lookup result reflects the state from before that update.
- R8: The counter index is taken from the PC starting at bit 2. Training one word address therefore does not change the prediction of the adjacent word address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | 32 | Fetch PC to look up |
| pred_taken | output | 1 | Lookup predicts a taken branch |
| pred_next_pc | output | 32 | Predicted next fetch address |
| upd_valid | input | 1 | Resolved branch update present this cycle |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| upd_target | input | 32 | Resolved branch destination |

## Verification
Lookup and training can fall in the same cycle on the same counter and target entry. The bench provokes this by driving an update and a lookup of one PC together. It checks that the answer in that cycle still shows the old counter state and old target. Only the lookup in the following cycle may show the trained state. A second case aliases two branches onto one entry, so that a taken update from one branch evicts the other's tag while the shared counter stays taken.

// File: rtl/bp_pkg.sv
package bp_pkg;

    localparam int ADDR_W   = 32;
    localparam int WORD_LSB = 2;

    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_e;

    // One saturating step of a direction counter toward the outcome
    function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
        logic [1:0] nxt;
        if (taken) begin
            nxt = (cur == CTR_ST) ? cur : cur + 2'd1;
        end else begin
            nxt = (cur == CTR_SNT) ? cur : cur - 2'd1;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/bp_dir_table.sv
module bp_dir_table #(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    import bp_pkg::*;

    typedef struct packed {
        logic [ENTRIES-1:0][1:0] ctr;
    } dir_state_t;

    dir_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ctr[wr_idx] = ctr_step(st_q.ctr[wr_idx], wr_taken);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                st_q.ctr[i] <= CTR_WNT;
            end
        end else begin
            st_q <= st_d;
        end
    end

    // Read is taken from registered state: same-cycle writes are not visible
    assign rd_taken = st_q.ctr[rd_idx][1];

endmodule

// File: rtl/bp_target_buf.sv
module bp_target_buf #(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 32,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int TAG_W  = ADDR_W - bp_pkg::WORD_LSB - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_pc,
    output logic              rd_hit,
    output logic [ADDR_W-1:0] rd_target,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_pc,
    input  logic [ADDR_W-1:0] wr_target
);
    import bp_pkg::*;

    localparam int TAG_LSB = WORD_LSB + IDX_W;

    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0][TAG_W-1:0]  tag;
        logic [ENTRIES-1:0][ADDR_W-1:0] tgt;
    } tb_state_t;

    tb_state_t st_d, st_q;

    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic [TAG_W-1:0] rd_tag, wr_tag;

    assign rd_idx = rd_pc[WORD_LSB +: IDX_W];
    assign rd_tag = rd_pc[TAG_LSB +: TAG_W];
    assign wr_idx = wr_pc[WORD_LSB +: IDX_W];
    assign wr_tag = wr_pc[TAG_LSB +: TAG_W];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.vld[wr_idx] = 1'b1;
            st_d.tag[wr_idx] = wr_tag;
            st_d.tgt[wr_idx] = wr_target;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_hit    = st_q.vld[rd_idx] && (st_q.tag[rd_idx] == rd_tag);
    assign rd_target = st_q.tgt[rd_idx];

endmodule

// File: rtl/bp_fetch_predictor.sv
module bp_fetch_predictor #(
    parameter int DIR_ENTRIES = 64,
    parameter int BTB_ENTRIES = 16,
    parameter int ADDR_W      = bp_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_pc,
    output logic              pred_taken,
    output logic [ADDR_W-1:0] pred_next_pc,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_target
);
    import bp_pkg::*;

    localparam int DIR_IDX_W = $clog2(DIR_ENTRIES);
    localparam logic [ADDR_W-1:0] SEQ_STEP = ADDR_W'(4);

    logic              dir_taken;
    logic              btb_hit;
    logic [ADDR_W-1:0] btb_target;

    bp_dir_table #(
        .ENTRIES (DIR_ENTRIES)
    ) u_dir (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_pc[WORD_LSB +: DIR_IDX_W]),
        .rd_taken (dir_taken),
        .wr_en    (upd_valid),
        .wr_idx   (upd_pc[WORD_LSB +: DIR_IDX_W]),
        .wr_taken (upd_taken)
    );

    bp_target_buf #(
        .ENTRIES (BTB_ENTRIES),
        .ADDR_W  (ADDR_W)
    ) u_btb (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_pc     (lk_pc),
        .rd_hit    (btb_hit),
        .rd_target (btb_target),
        .wr_en     (upd_valid && upd_taken),
        .wr_pc     (upd_pc),
        .wr_target (upd_target)
    );

    always_comb begin
        pred_taken   = dir_taken && btb_hit;
        pred_next_pc = pred_taken ? btb_target : lk_pc + SEQ_STEP;
    end

endmodule

// File: rtl/bp_fetch_predictor_chk.sv
module bp_fetch_predictor_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] lk_pc,
    input logic              pred_taken,
    input logic [ADDR_W-1:0] pred_next_pc,
    input logic              upd_valid,
    input logic [ADDR_W-1:0] upd_pc,
    input logic              upd_taken,
    input logic [ADDR_W-1:0] upd_target
);

    // First cycle out of reset: nothing trained yet
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !pred_taken);

    assert_fallthrough_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_taken |-> pred_next_pc == lk_pc + ADDR_W'(4));

    // Two taken outcomes in a row for one PC: next lookup of it predicts taken
    assert_two_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken) ##1 (upd_valid && upd_taken && upd_pc == $past(upd_pc))
        |=> (lk_pc != $past(upd_pc) || pred_taken));

    // Two not-taken outcomes in a row for one PC: next lookup of it falls through
    assert_two_not_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken) ##1 (upd_valid && !upd_taken && upd_pc == $past(upd_pc))
        |=> (lk_pc != $past(upd_pc) || !pred_taken));

    // A freshly written target is what a taken lookup of that PC returns
    assert_fresh_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken)
        |=> (lk_pc != $past(upd_pc) || !pred_taken || pred_next_pc == $past(upd_target)));

endmodule

bind bp_fetch_predictor bp_fetch_predictor_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_pc        (lk_pc),
    .pred_taken   (pred_taken),
    .pred_next_pc (pred_next_pc),
    .upd_valid    (upd_valid),
    .upd_pc       (upd_pc),
    .upd_taken    (upd_taken),
    .upd_target   (upd_target)
);

// File: tb/tb_bp_fetch_predictor.sv
module tb_bp_fetch_predictor;

    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 18;

    localparam logic [31:0] PA = 32'h0000_1000; // dir idx 0, btb idx 0
    localparam logic [31:0] PB = 32'h0000_1100; // aliases PA, other tag
    localparam logic [31:0] PC = 32'h0000_1004; // next word after PA
    localparam logic [31:0] TA = 32'h0000_2000;
    localparam logic [31:0] TB = 32'h0000_3000;
    localparam logic [31:0] TC = 32'h0000_4000;

    typedef struct packed {
        logic        uv;
        logic [31:0] upc;
        logic        ut;
        logic [31:0] utgt;
        logic [31:0] lpc;
        logic        et;
        logic [31:0] enpc;
        logic [3:0]  req;
    } vec_t;

    // Lookup is judged against state before the same row's update
    localparam vec_t VEC [N_VEC] = '{
        '{1'b0, 32'h0, 1'b0, 32'h0, PA, 1'b0, PA + 32'd4, 4'd1}, // R1
        '{1'b1, PA,    1'b1, TA,    PA, 1'b0, PA + 32'd4, 4'd7}, // R7 same cycle
        '{1'b0, 32'h0, 1'b0, 32'h0, PA, 1'b1, TA,         4'd4}, // R4
        '{1'b1, PA,    1'b1, TA,    PC, 1'b0, PC + 32'd4, 4'd8}, // R8
        '{1'b1, PA,    1'b1, TA,    PA, 1'b1, TA,         4'd5}, // R5 saturate 11
        '{1'b1, PA,    1'b0, 32'h0, PA, 1'b1, TA,         4'd7}, // R7
        '{1'b0, 32'h0, 1'b0, 32'h0, PA, 1'b1, TA,         4'd5}, // R5 one miss keeps, R6
        '{1'b1, PA,    1'b0, 32'h0, PB, 1'b0, PB + 32'd4, 4'd3}, // R3 tag mismatch
        '{1'b0, 32'h0, 1'b0, 32'h0, PA, 1'b0, PA + 32'd4, 4'd5}, // R5 second flips
        '{1'b1, PA,    1'b0, 32'h0, PA, 1'b0, PA + 32'd4, 4'd2}, // R2
        '{1'b1, PA,    1'b0, 32'h0, PA, 1'b0, PA + 32'd4, 4'd5}, // R5 saturate 00
        '{1'b1, PA,    1'b1, TB,    PA, 1'b0, PA + 32'd4, 4'd2}, // R2
        '{1'b0, 32'h0, 1'b0, 32'h0, PA, 1'b0, PA + 32'd4, 4'd5}, // R5 one taken from 00
        '{1'b1, PA,    1'b1, TB,    PA, 1'b0, PA + 32'd4, 4'd7}, // R7
        '{1'b0, 32'h0, 1'b0, 32'h0, PA, 1'b1, TB,         4'd6}, // R6 replaced target
        '{1'b1, PB,    1'b1, TA,    PA, 1'b1, TB,         4'd7}, // R7
        '{1'b0, 32'h0, 1'b0, 32'h0, PA, 1'b0, PA + 32'd4, 4'd6}, // R6 evicted by PB
        '{1'b0, 32'h0, 1'b0, 32'h0, PB, 1'b1, TA,         4'd4}  // R4
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        pred_taken;
    logic [31:0] pred_next_pc;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bp_fetch_predictor dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .lk_pc        (lk_pc),
        .pred_taken   (pred_taken),
        .pred_next_pc (pred_next_pc),
        .upd_valid    (upd_valid),
        .upd_pc       (upd_pc),
        .upd_taken    (upd_taken),
        .upd_target   (upd_target)
    );

    task automatic check(input int req, input logic exp_t, input logic [31:0] exp_pc);
        n_checks++;
        if (pred_taken !== exp_t || pred_next_pc !== exp_pc) begin
            n_fail++;
            $display("FAIL R%0d: lookup %h got taken=%b next=%h, expected taken=%b next=%h",
                     req, lk_pc, pred_taken, pred_next_pc, exp_t, exp_pc);
        end
    endtask

    task automatic step(input logic uv, input logic [31:0] upc, input logic ut,
                        input logic [31:0] utgt, input logic [31:0] lpc);
        @(negedge clk);
        upd_valid  = uv;
        upd_pc     = upc;
        upd_taken  = ut;
        upd_target = utgt;
        lk_pc      = lpc;
        #2;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog (all requirements): got no finish, expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < N_VEC; i++) begin
            step(VEC[i].uv, VEC[i].upc, VEC[i].ut, VEC[i].utgt, VEC[i].lpc);
            check(int'(VEC[i].req), VEC[i].et, VEC[i].enpc);
        end

        // R1: reset mid-run clears trained state (PB was taken to TA)
        @(negedge clk);
        upd_valid = 1'b0;
        lk_pc     = PB;
        rst_n     = 1'b0;
        #2;
        check(1, 1'b0, PB + 32'd4);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 32'h0, 1'b0, 32'h0, PA);
        check(1, 1'b0, PA + 32'd4);

        // R8: train the adjacent word twice; it predicts, PA does not
        step(1'b1, PC, 1'b1, TC, PC);
        check(8, 1'b0, PC + 32'd4);
        step(1'b1, PC, 1'b1, TC, PA);
        check(8, 1'b0, PA + 32'd4);
        step(1'b0, 32'h0, 1'b0, 32'h0, PC);
        check(8, 1'b1, TC);
        step(1'b0, 32'h0, 1'b0, 32'h0, PA);
        check(8, 1'b0, PA + 32'd4);

        // R2: fall-through wraps at the top of the address space
        step(1'b0, 32'h0, 1'b0, 32'h0, 32'hFFFF_FFFC);
        check(2, 1'b0, 32'h0000_0000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule